// File: doc/BRIEF.md
# Three-Phase Gate Drive Interlock

This block is the digital core of a three-phase half-bridge pre-driver. Each phase has a high-side command (active low) and a low-side command (active high). From them it makes one high-side and one low-side gate output. It keeps the two switches of a phase from conducting together, and it inserts a programmable blanking gap before a switch turns on after its partner turns off. A two-bit bypass input can switch off either of these protections.

Two enable inputs gate every output with no clock in the path. While either enable is low, or while reset is asserted, all six gates are low. The enables also pass through a two-stage synchronizer into the sequential state. When that synchronized run level is low, the per-phase "bootstrap armed" flags clear. After the enables return, each phase's high side stays blocked until its own low side has been on for at least one cycle. This lets the bootstrap capacitor charge before the high-side switch is used.

Top module: `gate_interlock_core`

## Requirements
- R1: Whenever `en_a` or `en_b` is low, all six gate outputs are low at once, without waiting for a clock edge. The configuration inputs keep their values and need no reload.
- R2: While `rst_n` is low, all gate outputs are low. After release, every phase is disarmed and no dead-time delay is pending.
- R3: The enables reach the sequential state through two flip-flops. While that synchronized level is low, every phase is disarmed. A phase's high-side gate can turn on only after its low-side gate has been high in an earlier cycle since it was last disarmed.
- R4: `hs_cmd_n[p]` = 0 requests the high side of phase p, and `ls_cmd[p]` = 1 requests the low side. With the block enabled, the phase armed and no blanking pending, a gate follows its command one clock later.
- R5: With `ilk_bypass` = 0, a phase whose two commands both request on drives both of its gates low. Its high and low gates are never high together.
- R6: With `ilk_bypass` = 1, both gates of a phase follow their own commands and may be high together.
- R7: With `dt_bypass` = 0 and `dt_count` = D, a gate rises only after its complementary gate has been low for at least D whole clock cycles. D = 0 allows the swap on a single edge.
- R8: With `dt_bypass` = 1, turn-on is not delayed, whatever the value of `dt_count`.
- R9: The three phases are independent. A command, conflict or arming event in one phase does not change the gates of another phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_a | input | 1 | First gate enable, active high |
| en_b | input | 1 | Second gate enable, active high |
| hs_cmd_n | input | 3 | High-side commands, active low, one bit per phase |
| ls_cmd | input | 3 | Low-side commands, active high, one bit per phase |
| dt_count | input | 8 | Dead-time length in clock cycles |
| ilk_bypass | input | 1 | 1 disables the per-phase interlock |
| dt_bypass | input | 1 | 1 disables dead-time blanking |
| hs_gate | output | 3 | High-side gate drives |
| ls_gate | output | 3 | Low-side gate drives |

## Verification
Directed sequences cover several cases, each aimed at one rule:
- A high-side request right after enable shows whether the bootstrap hold-off works.
- A low-to-high swap with a non-zero dead time shows whether the gap is exactly D idle cycles.
- The same swap with blanking bypassed shows the gap drop to zero.
- Simultaneous requests, with and without the interlock bypass, tell the conflict rule apart from free-running gates.
- A mid-cycle enable drop and a mid-cycle reset, each followed by a re-enable, show that gates fall without a clock and that arming starts over.

Long random command streams, with varied dead times and bypass settings, then exercise all phases together. The bench compares every gate against a behavioural model on every cycle.

// File: rtl/gdi_pkg.sv
package gdi_pkg;
    // Protection override bits applied to every phase
    typedef struct packed {
        logic ilk_off;
        logic dt_off;
    } bypass_t;
endpackage

// File: rtl/gdi_sync.sv
module gdi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/gdi_phase.sv
module gdi_phase
    import gdi_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            hs_req,
    input  logic            ls_req,
    input  logic [DT_W-1:0] dt_count,
    input  bypass_t         byp,
    output logic            hs_q_o,
    output logic            ls_q_o
);
    localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

    typedef struct packed {
        logic            hs;
        logic            ls;
        logic            armed;
        logic [DT_W-1:0] hs_off;   // cycles the high gate has been low
        logic [DT_W-1:0] ls_off;   // cycles the low gate has been low
    } ph_state_t;

    localparam ph_state_t ST_RESET = '{hs: 1'b0, ls: 1'b0, armed: 1'b0,
                                       hs_off: CNT_MAX, ls_off: CNT_MAX};

    ph_state_t st_d, st_q;
    logic      want_hs, want_ls, hs_clear, ls_clear;

    always_comb begin
        st_d     = st_q;
        // a request survives only if the partner is not also requested, unless bypassed
        want_hs  = hs_req && (byp.ilk_off || !ls_req) && st_q.armed;
        want_ls  = ls_req && (byp.ilk_off || !hs_req);
        // blanking: partner low long enough, already on, or bypassed
        hs_clear = st_q.hs || byp.dt_off || (st_q.ls_off >= dt_count);
        ls_clear = st_q.ls || byp.dt_off || (st_q.hs_off >= dt_count);
        if (run) begin
            st_d.hs    = want_hs && hs_clear;
            st_d.ls    = want_ls && ls_clear;
            st_d.armed = st_q.armed || st_q.ls;
        end else begin
            st_d.hs    = 1'b0;
            st_d.ls    = 1'b0;
            st_d.armed = 1'b0;
        end
        st_d.hs_off = st_d.hs ? '0 : ((st_q.hs_off == CNT_MAX) ? CNT_MAX : st_q.hs_off + 1'b1);
        st_d.ls_off = st_d.ls ? '0 : ((st_q.ls_off == CNT_MAX) ? CNT_MAX : st_q.ls_off + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign hs_q_o = st_q.hs;
    assign ls_q_o = st_q.ls;

    // R5
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byp.ilk_off |=> !(st_q.hs && st_q.ls));

    // R5
    conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp.ilk_off && hs_req && ls_req) |=> (!st_q.hs && !st_q.ls));

    // R3
    boot_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hs) |-> $past(st_q.armed));

    // R3
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!st_q.hs && !st_q.ls && !st_q.armed));

    // R7
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.hs) && !$past(byp.dt_off) && ($past(dt_count) != '0)) |-> !$past(st_q.ls));
endmodule

// File: rtl/gate_interlock_core.sv
module gate_interlock_core
    import gdi_pkg::*;
#(
    parameter int NPH   = 3,
    parameter int DT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_a,
    input  logic            en_b,
    input  logic [NPH-1:0]  hs_cmd_n,
    input  logic [NPH-1:0]  ls_cmd,
    input  logic [DT_W-1:0] dt_count,
    input  logic            ilk_bypass,
    input  logic            dt_bypass,
    output logic [NPH-1:0]  hs_gate,
    output logic [NPH-1:0]  ls_gate
);
    logic           run;
    logic           gate_ok;
    bypass_t        byp;
    logic [NPH-1:0] hs_q, ls_q;

    assign byp = '{ilk_off: ilk_bypass, dt_off: dt_bypass};

    gdi_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (en_a & en_b),
        .dout (run)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        gdi_phase #(.DT_W(DT_W)) u_ph (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .hs_req  (~hs_cmd_n[p]),
            .ls_req  (ls_cmd[p]),
            .dt_count(dt_count),
            .byp     (byp),
            .hs_q_o  (hs_q[p]),
            .ls_q_o  (ls_q[p])
        );
    end

    // clock-free forcing path
    assign gate_ok = en_a & en_b & rst_n;
    assign hs_gate = hs_q & {NPH{gate_ok}};
    assign ls_gate = ls_q & {NPH{gate_ok}};
endmodule

// File: tb/tb_gate_interlock_core.sv
module tb_gate_interlock_core;
    localparam int NPH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_a = 1'b0, en_b = 1'b0;
    logic [2:0] hs_cmd_n = 3'b111;
    logic [2:0] ls_cmd = 3'b000;
    logic [7:0] dt_count = 8'd0;
    logic       ilk_bypass = 1'b0, dt_bypass = 1'b0;
    logic [2:0] hs_gate, ls_gate;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R2";

    gate_interlock_core dut (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
        .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd), .dt_count(dt_count),
        .ilk_bypass(ilk_bypass), .dt_bypass(dt_bypass),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    always #4 clk = ~clk;

    // behavioural reference
    bit m_s1, m_s2;
    bit m_hs [NPH], m_ls [NPH], m_arm [NPH];
    int m_hoff [NPH], m_loff [NPH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0;
            for (int p = 0; p < NPH; p++) begin
                m_hs[p] = 0; m_ls[p] = 0; m_arm[p] = 0; m_hoff[p] = 255; m_loff[p] = 255;
            end
        end else begin
            for (int p = 0; p < NPH; p++) begin
                bit hr, lr, wh, wl, nh, nl;
                hr = !hs_cmd_n[p]; lr = ls_cmd[p];
                if (!m_s2) begin
                    nh = 0; nl = 0; m_arm[p] = 0;
                end else begin
                    wh = hr && (ilk_bypass || !lr) && m_arm[p];
                    wl = lr && (ilk_bypass || !hr);
                    nh = wh && (m_hs[p] || dt_bypass || m_loff[p] >= dt_count);
                    nl = wl && (m_ls[p] || dt_bypass || m_hoff[p] >= dt_count);
                    m_arm[p] = m_arm[p] || m_ls[p];
                end
                m_hs[p] = nh; m_ls[p] = nl;
                m_hoff[p] = nh ? 0 : (m_hoff[p] < 255 ? m_hoff[p] + 1 : 255);
                m_loff[p] = nl ? 0 : (m_loff[p] < 255 ? m_loff[p] + 1 : 255);
            end
            m_s2 = m_s1; m_s1 = en_a && en_b;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            bit g;
            logic [2:0] eh, el;
            g = en_a && en_b && rst_n;
            for (int p = 0; p < NPH; p++) begin
                eh[p] = m_hs[p] && g;
                el[p] = m_ls[p] && g;
            end
            check(hs_gate === eh, {cur_req, " hs"}, hs_gate, eh);
            check(ls_gate === el, {cur_req, " ls"}, ls_gate, el);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    // count both-low cycles of phase 0 before the high gate rises
    task automatic gap_p0(output int gap);
        gap = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (hs_gate[0]) break;
            if (!ls_gate[0]) gap++;
        end
    endtask

    initial begin
        int gap;
        tick(2);
        check(hs_gate == 0 && ls_gate == 0, "R2 reset", {hs_gate, ls_gate}, 0);
        rst_n = 1; tick();
        cur_req = "R3";
        en_a = 1; en_b = 1; tick(4);
        hs_cmd_n = 3'b110; tick(4);
        check(hs_gate[0] == 0, "R3 high side before arming", hs_gate[0], 0);
        hs_cmd_n = 3'b111; ls_cmd = 3'b001; tick(2);
        cur_req = "R4";
        check(ls_gate == 3'b001, "R4 low side follows", ls_gate, 1);
        cur_req = "R7";
        dt_count = 8'd5; ls_cmd = 3'b000; hs_cmd_n = 3'b110;
        gap_p0(gap);
        check(gap == 5, "R7 dead time 5", gap, 5);
        check(hs_gate[0] == 1, "R4 high side follows", hs_gate[0], 1);
        cur_req = "R5";
        ls_cmd = 3'b001; tick(2);
        check(hs_gate[0] == 0 && ls_gate[0] == 0, "R5 conflict both off", {hs_gate[0], ls_gate[0]}, 0);
        check(hs_gate[2:1] == 0 && ls_gate[2:1] == 0, "R9 other phases idle", {hs_gate[2:1], ls_gate[2:1]}, 0);
        cur_req = "R6";
        ilk_bypass = 1; dt_bypass = 1; tick(2);
        check(hs_gate[0] == 1 && ls_gate[0] == 1, "R6 bypass both on", {hs_gate[0], ls_gate[0]}, 3);
        cur_req = "R8";
        ilk_bypass = 0; hs_cmd_n = 3'b111; dt_count = 8'd200; tick(3);
        hs_cmd_n = 3'b110; ls_cmd = 3'b000;
        gap_p0(gap);
        check(gap == 0, "R8 no blanking when bypassed", gap, 0);
        dt_bypass = 0;
        cur_req = "R7";
        dt_count = 8'd0; hs_cmd_n = 3'b111; ls_cmd = 3'b001; tick(3);
        ls_cmd = 3'b000; hs_cmd_n = 3'b110;
        gap_p0(gap);
        check(gap == 0, "R7 dead time 0", gap, 0);
        cur_req = "R1";
        @(negedge clk); #2 en_b = 0; #1;
        check(hs_gate == 0 && ls_gate == 0, "R1 async force off", hs_gate, 0);
        check(dt_count == 0 && dt_bypass == 0, "R1 config kept", dt_count, 0);
        tick(4); en_b = 1; tick(4);
        check(hs_gate[0] == 0, "R3 disarmed after re-enable", hs_gate[0], 0);
        ls_cmd = 3'b001; hs_cmd_n = 3'b111; tick(3);
        ls_cmd = 3'b000; hs_cmd_n = 3'b110; tick(3);
        check(hs_gate[0] == 1, "R3 high side after low pulse", hs_gate[0], 1);
        cur_req = "R2";
        @(negedge clk); #2 rst_n = 0; #1;
        check(hs_gate == 0 && ls_gate == 0, "R2 async reset", hs_gate, 0);
        tick(2); rst_n = 1; tick(5);
        check(hs_gate[0] == 0, "R2 disarmed after reset", hs_gate[0], 0);
        // random streams over all phases
        cur_req = "R9";
        for (int blk = 0; blk < 40; blk++) begin
            dt_count   = 8'($urandom_range(0, 9));
            ilk_bypass = ($urandom_range(0, 5) == 0);
            dt_bypass  = ($urandom_range(0, 4) == 0);
            for (int k = 0; k < 150; k++) begin
                hs_cmd_n = 3'($urandom);
                ls_cmd   = 3'($urandom);
                if ($urandom_range(0, 60) == 0) en_a = 0;
                else if ($urandom_range(0, 3) == 0) en_a = 1;
                tick($urandom_range(1, 4));
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule